// File: doc/BRIEF.md
# PCI Configuration and I/O Access Port

This block gives a host a small register window for reaching a PCI bus indirectly. The host first writes a 32-bit address register. It then reads or writes a configuration data register to run a configuration cycle at that address, or one of four I/O window bytes to run an I/O cycle near it. Host accesses name a 4-bit offset and a size code. The block turns each legal access into a single downstream request and holds it until the downstream side acknowledges. It then returns one completion to the host.

The address register keeps the exact value that was written, so a read returns it unchanged. Cycles use that value with its two lowest bits forced to zero. No enable bit is checked before a configuration cycle is issued. Configuration data is carried in little-endian byte lanes and I/O window data in big-endian order. Offset and size pairs that are not allowed complete at once with an error and send nothing downstream.

Top module: `pci_cfg_io_port`

## Requirements
- R1: After reset the address register reads 0, `h_ready` is high, and `h_done` and `d_req` are low.
- R2: Offsets 0x0 to 0x3 hold the address register. Only a word access (size code 2) at offset 0x0 is legal there. A legal access completes in the cycle after acceptance without a downstream request. An illegal one leaves the register unchanged.
- R3: A read of the address register returns the raw value last written. Every cycle address is built from that value with bits [1:0] cleared.
- R4: A configuration access (offsets 0x4 to 0x7) raises `d_req` with `d_io`=0 and `d_addr` = effective address OR offset[1:0], whatever the value of address bit 31.
- R5: Configuration accesses are legal when naturally aligned (byte anywhere, halfword at an even offset, word at 0x4). They use little-endian lanes: value byte k goes to lane offset[1:0]+k, `d_be` marks exactly those lanes, and the other lanes are zero. Read data is taken back from the same lanes and zero-extended.
- R6: An I/O access (offsets 0x8 to 0xB) raises `d_req` with `d_io`=1 and `d_addr` = effective address + offset[1:0]. Offset 0x8 allows any size, 0xA allows byte or halfword, and 0x9 and 0xB allow bytes only.
- R7: I/O data is big-endian. For an access of n bytes, value byte n-1-k goes to lane offset[1:0]+k, and reads reverse this.
- R8: Size code 3, offsets 0xC to 0xF, and every combination disallowed above complete in the cycle after acceptance with `h_err` high and no downstream request.
- R9: `d_req` and its fields stay unchanged until `d_ack`. The completion pulse `h_done` (one cycle) follows in the next cycle, and `h_ready` stays low from acceptance until that pulse has ended. Write completions return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Block can accept an access |
| h_we | input | 1 | 1 = write, 0 = read |
| h_off | input | 4 | Register offset |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| h_wdata | input | 32 | Host write value, right-aligned |
| h_done | output | 1 | One-cycle completion pulse |
| h_err | output | 1 | Completion is an error |
| h_rdata | output | 32 | Read value, right-aligned |
| d_req | output | 1 | Downstream request pending |
| d_io | output | 1 | 1 = I/O cycle, 0 = configuration cycle |
| d_we | output | 1 | Downstream direction |
| d_addr | output | 32 | Downstream byte address |
| d_be | output | 4 | Byte-lane enables |
| d_wdata | output | 32 | Lane-placed write data |
| d_ack | input | 1 | Downstream completion |
| d_rdata | input | 32 | Lane-placed read data |

## Verification
The hardest case to reach is a halfword or word I/O read whose bytes come back reversed from a downstream word while the address register holds awkward low bits and a set bit 31. Random offset, size and address-register values reach most of these pairings. Directed accesses cover every legal and illegal pairing of I/O offset and size. The downstream model waits a random 0 to 3 cycles before acknowledging, so the held request and the ready gating are tested under stalls.

// File: rtl/pci_cfg_io_port.sv
module pci_cfg_io_port #(
  parameter logic [31:0] ADDR_RESET = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_valid,
  output logic        h_ready,
  input  logic        h_we,
  input  logic [3:0]  h_off,
  input  logic [1:0]  h_size,
  input  logic [31:0] h_wdata,
  output logic        h_done,
  output logic        h_err,
  output logic [31:0] h_rdata,
  output logic        d_req,
  output logic        d_io,
  output logic        d_we,
  output logic [31:0] d_addr,
  output logic [3:0]  d_be,
  output logic [31:0] d_wdata,
  input  logic        d_ack,
  input  logic [31:0] d_rdata
);
  localparam logic [1:0] WIN_ADDR = 2'd0;
  localparam logic [1:0] WIN_CFG  = 2'd1;
  localparam logic [1:0] WIN_IO   = 2'd2;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] reorder(input logic [31:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    reorder = {24'h0, v[7:0]};
      2'd1:    reorder = {16'h0, v[7:0], v[15:8]};
      default: reorder = {v[7:0], v[15:8], v[23:16], v[31:24]};
    endcase
  endfunction

  logic [31:0] addr_raw;
  logic        busy;
  logic [1:0]  q_lo, q_size;
  logic        legal;

  wire [1:0]  win    = h_off[3:2];
  wire [1:0]  lo     = h_off[1:0];
  wire        accept = h_valid && h_ready;
  wire [31:0] eff    = {addr_raw[31:2], 2'b00};
  wire [3:0]  lanes  = (h_size == 2'd0) ? 4'b0001 : (h_size == 2'd1) ? 4'b0011 : 4'b1111;
  wire [31:0] w_val  = (win == WIN_IO) ? reorder(h_wdata, h_size) : (h_wdata & size_mask(h_size));
  wire [31:0] r_sh   = d_rdata >> {q_lo, 3'b000};
  wire [31:0] r_val  = d_io ? reorder(r_sh, q_size) : (r_sh & size_mask(q_size));

  assign h_ready = !busy && !h_done;
  assign d_req   = busy;

  always_comb begin
    legal = 1'b0;
    if (h_size != 2'd3) begin
      case (win)
        WIN_ADDR: legal = (h_size == 2'd2) && (lo == 2'd0);
        WIN_CFG:  legal = (h_size == 2'd0) || (h_size == 2'd1 && !lo[0]) || (lo == 2'd0);
        WIN_IO:   legal = (lo == 2'd0) || (lo == 2'd2 && h_size != 2'd2) || (h_size == 2'd0);
        default:  legal = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_raw <= ADDR_RESET;
      busy     <= 1'b0;
      h_done   <= 1'b0;
      h_err    <= 1'b0;
      h_rdata  <= '0;
      d_io     <= 1'b0;
      d_we     <= 1'b0;
      d_addr   <= '0;
      d_be     <= '0;
      d_wdata  <= '0;
      q_lo     <= '0;
      q_size   <= '0;
    end else begin
      h_done <= 1'b0;
      if (accept) begin
        if (!legal) begin
          h_done  <= 1'b1;
          h_err   <= 1'b1;
          h_rdata <= '0;
        end else if (win == WIN_ADDR) begin
          h_done  <= 1'b1;
          h_err   <= 1'b0;
          h_rdata <= h_we ? 32'h0 : addr_raw;
          if (h_we) addr_raw <= h_wdata;
        end else begin
          busy    <= 1'b1;
          d_io    <= (win == WIN_IO);
          d_we    <= h_we;
          d_addr  <= (win == WIN_IO) ? eff + {30'h0, lo} : (eff | {30'h0, lo});
          d_be    <= lanes << lo;
          d_wdata <= w_val << {lo, 3'b000};
          q_lo    <= lo;
          q_size  <= h_size;
        end
      end else if (busy && d_ack) begin
        busy    <= 1'b0;
        h_done  <= 1'b1;
        h_err   <= 1'b0;
        h_rdata <= d_we ? 32'h0 : r_val;
      end
    end
  end
endmodule

// File: rtl/pci_cfg_io_port_chk.sv
module pci_cfg_io_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_valid,
  input logic        h_ready,
  input logic [3:0]  h_off,
  input logic [1:0]  h_size,
  input logic        h_done,
  input logic        h_err,
  input logic        d_req,
  input logic        d_ack,
  input logic        d_io,
  input logic [31:0] d_addr,
  input logic [3:0]  d_be
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    h_done |=> !h_done);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_ack) |=> (d_req && $stable(d_addr) && $stable(d_be) && $stable(d_io)));

  assert_ack_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && d_ack) |=> (h_done && !h_err && !d_req));

  assert_bad_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && h_size == 2'd3) |=> (h_done && h_err && !d_req));

  assert_upper_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && h_off[3:2] == 2'd3) |=> (h_done && h_err && !d_req));

  assert_addr_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && h_off[3:2] == 2'd0) |=> (h_done && !d_req));

  assert_odd_io_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && d_io && d_addr[0]) |-> ($countones(d_be) == 1));

  assert_lane_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> ($countones(d_be) != 0 && $countones(d_be) != 3));
endmodule

bind pci_cfg_io_port pci_cfg_io_port_chk i_chk (.*);

// File: tb/test_pci_cfg_io_port.sv
module test_pci_cfg_io_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_valid = 1'b0, h_we = 1'b0, d_ack = 1'b0;
  logic [3:0] h_off = '0;
  logic [1:0] h_size = '0;
  logic [31:0] h_wdata = '0, d_rdata = '0;
  logic h_ready, h_done, h_err, d_req, d_io, d_we;
  logic [31:0] h_rdata, d_addr, d_wdata;
  logic [3:0] d_be;
  int checks = 0, fails = 0;
  logic [31:0] raw = 32'h0;

  always #2.5 clk = ~clk;

  pci_cfg_io_port i_pci_cfg_io_port (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ok(input logic [3:0] off, input logic [1:0] sz);
    int n = 1 << sz;
    if (sz == 3) return 0;
    case (off[3:2])
      0: return off == 0 && sz == 2;
      1: return (off[1:0] % n) == 0;
      2: return (off[1:0] == 0) || (off[1:0] == 2 && sz <= 1) || sz == 0;
      default: return 0;
    endcase
  endfunction

  task automatic access(input logic we, input logic [3:0] off, input logic [1:0] sz,
                        input logic [31:0] wv);
    int n = 1 << sz;
    int lo = off[1:0];
    bit io = off[3:2] == 2;
    logic [31:0] ew = 0, er = 0, rd;
    logic [3:0] eb = 0;
    @(negedge clk);
    h_valid = 1; h_we = we; h_off = off; h_size = sz; h_wdata = wv;
    @(negedge clk);
    h_valid = 0;
    if (!ok(off, sz)) begin
      chk("R8 err", {h_done, h_err, d_req}, 3'b110);
    end else if (off[3:2] == 0) begin
      chk("R2 local", {h_done, h_err, d_req}, 3'b100);
      chk("R3 readback", h_rdata, we ? 32'h0 : raw);
      if (we) raw = wv;
    end else begin
      rd = $urandom;
      for (int k = 0; k < n; k++) begin
        int vb = io ? n - 1 - k : k;
        eb[lo + k] = 1'b1;
        ew[8*(lo+k) +: 8] = wv[8*vb +: 8];
        er[8*vb +: 8] = rd[8*(lo+k) +: 8];
      end
      chk(io ? "R6 req" : "R4 req", {d_req, d_io, d_we, h_done}, {1'b1, io, we, 1'b0});
      chk(io ? "R6 addr" : "R4 addr", d_addr, {raw[31:2], 2'b00} + lo);
      chk(io ? "R7 be" : "R5 be", {28'h0, d_be}, {28'h0, eb});
      if (we) chk(io ? "R7 wdata" : "R5 wdata", d_wdata, ew);
      repeat ($urandom % 4) begin
        @(negedge clk);
        chk("R9 hold", {d_req, h_ready, h_done}, 3'b100);
      end
      d_ack = 1; d_rdata = rd;
      @(negedge clk);
      d_ack = 0;
      chk("R9 done", {h_done, h_err, d_req, h_ready}, 4'b1000);
      chk(io ? "R7 rdata" : "R5 rdata", h_rdata, we ? 32'h0 : er);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", {h_ready, h_done, d_req}, 3'b100);
    access(0, 4'h0, 2, 0);
    access(1, 4'h0, 2, 32'h0000_1237);
    access(0, 4'h0, 2, 0);
    access(1, 4'h0, 1, 32'hDEAD_BEEF);
    access(1, 4'h1, 0, 32'hDEAD_BEEF);
    access(0, 4'h0, 2, 0);
    access(1, 4'h4, 2, 32'hA1B2_C3D4);
    access(0, 4'h6, 1, 0);
    access(0, 4'h5, 1, 0);
    access(1, 4'h0, 2, 32'h8000_ABCF);
    access(0, 4'h7, 0, 0);
    for (int o = 8; o < 16; o++)
      for (int s = 0; s < 4; s++) access(o[0], o[3:0], s[1:0], 32'h1122_3344);
    for (int i = 0; i < 400; i++) begin
      if (i % 25 == 0) access(1, 4'h0, 2, $urandom);
      else access($urandom % 2, $urandom % 16, $urandom % 4, $urandom);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule